// File: doc/BRIEF.md
# Multicart Program and Pattern Bank Mapper

This block holds the bank-switching state for a game cartridge that carries many titles in one 2 MiB program ROM and one 8 KiB pattern RAM. It watches the CPU write bus. Any write in the upper half of the 16-bit address space lands in one of two write-only control registers. Address bit 0 picks which register; the rest of the address plays no part.

From those registers the block builds three outputs. The first is the 21-bit program ROM address, taken from a 6-bit 32 KiB page number. In 16 KiB mode a half-select bit replaces CPU address bit 14. The second is the line that picks which of the console's two internal nametables the video bus reaches. The third is a write enable for the pattern RAM, which a protect flag can hold low. The ROM and RAM arrays, CPU reads and work RAM are outside the block.

Top module: `mcm_mapper`

## Requirements
- R1: A synchronous active-high `rst` clears every stored bit. After reset, the page is 0, 32 KiB mode is active, the nametable line follows `ppu_addr[11]`, and pattern writes pass through.
- R2: A CPU write with `cpu_addr[15]`=1 and `cpu_addr[0]`=0 loads the even register on that clock edge:
  - data bit 7 is page bit 4
  - bit 6 is the mirroring select
  - bit 5 is the 16 KiB mode flag
  - bits 4..1 are page bits 3..0
  - bit 0 is the half select

  A write with `cpu_addr[0]`=1 loads the odd register: bit 1 is the protect flag and bit 0 is page bit 5. Address bits 14..1 do not affect decoding.
- R3: CPU writes with `cpu_addr[15]`=0 leave all state unchanged.
- R4: Data bits 7..2 of an odd-register write have no effect.
- R5: In 32 KiB mode, `rom_addr` = {page[5:0], `cpu_addr[14:0]`}.
- R6: In 16 KiB mode, `rom_addr` = {page[5:0], half select, `cpu_addr[13:0]`}, so both CPU windows show the same half.
- R7: `nt_sel` equals `ppu_addr[11]` when the mirroring select is 0 (horizontal mirroring) and `ppu_addr[10]` when it is 1 (vertical mirroring).
- R8: `chr_we` = `ppu_we` & ~`ppu_addr[13]` & ~protect, and `chr_addr` = `ppu_addr[12:0]`.
- R9: Writing $76 to an even address and $03 to an odd one gives page 43, 16 KiB mode with the lower half, vertical mirroring and pattern writes blocked.
- R10: Without qualifying writes, the stored state holds over any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 14 | Video bus address |
| ppu_we | input | 1 | Video bus write strobe |
| rom_addr | output | 21 | Program ROM address |
| nt_sel | output | 1 | Internal nametable select line |
| chr_addr | output | 13 | Pattern RAM address |
| chr_we | output | 1 | Gated pattern RAM write enable |

## Verification
The assertions assume that `cpu_we` is high for one cycle per write, and that `cpu_addr` and `cpu_wdata` are steady around the capturing edge. They also assume that the video address does not change in the cycle after a register write, so the mirroring check can compare against it. The bench drives every input on the falling edge and leaves the video bus still across each write. It probes outputs only while `cpu_we` is low, so results never depend on a write that is still being captured.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
    localparam int PAGE_W  = 6;
    localparam int BLOCK_W = 15;
    localparam int ROM_W   = PAGE_W + BLOCK_W;

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic              mirror_v;
        logic              half_mode;
        logic              half_sel;
        logic              wprot;
    } bank_state_t;
endpackage

// File: rtl/mcm_regs.sv
module mcm_regs
    import mcm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        sel_odd,
    input  logic [7:0]  wdata,
    output bank_state_t st_q
);
    bank_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (sel_odd) begin
                st_d.page[5] = wdata[0];
                st_d.wprot   = wdata[1];
            end else begin
                st_d.page[4]   = wdata[7];
                st_d.mirror_v  = wdata[6];
                st_d.half_mode = wdata[5];
                st_d.page[3:0] = wdata[4:1];
                st_d.half_sel  = wdata[0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/mcm_prg_map.sv
module mcm_prg_map
    import mcm_pkg::*;
(
    input  bank_state_t        st,
    input  logic [BLOCK_W-1:0] cpu_off,
    output logic [ROM_W-1:0]   rom_addr
);
    logic top_bit;

    always_comb begin
        top_bit  = st.half_mode ? st.half_sel : cpu_off[BLOCK_W-1];
        rom_addr = {st.page, top_bit, cpu_off[BLOCK_W-2:0]};
    end
endmodule

// File: rtl/mcm_vid_map.sv
module mcm_vid_map #(
    parameter int PPU_AW = 14
) (
    input  logic              mirror_v,
    input  logic              wprot,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              ppu_we,
    output logic              nt_sel,
    output logic [PPU_AW-2:0] chr_addr,
    output logic              chr_we
);
    always_comb begin
        nt_sel   = mirror_v ? ppu_addr[10] : ppu_addr[11];
        chr_addr = ppu_addr[PPU_AW-2:0];
        chr_we   = ppu_we & ~ppu_addr[PPU_AW-1] & ~wprot;
    end
endmodule

// File: rtl/mcm_mapper.sv
module mcm_mapper
    import mcm_pkg::*;
#(
    parameter int CPU_AW = 16,
    parameter int PPU_AW = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              ppu_we,
    output logic [ROM_W-1:0]  rom_addr,
    output logic              nt_sel,
    output logic [PPU_AW-2:0] chr_addr,
    output logic              chr_we
);
    bank_state_t st_q;
    logic        reg_wr;

    assign reg_wr = cpu_we & cpu_addr[CPU_AW-1];

    mcm_regs regs_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr),
        .sel_odd (cpu_addr[0]),
        .wdata   (cpu_wdata),
        .st_q    (st_q)
    );

    mcm_prg_map prg_i (
        .st       (st_q),
        .cpu_off  (cpu_addr[BLOCK_W-1:0]),
        .rom_addr (rom_addr)
    );

    mcm_vid_map #(.PPU_AW(PPU_AW)) vid_i (
        .mirror_v (st_q.mirror_v),
        .wprot    (st_q.wprot),
        .ppu_addr (ppu_addr),
        .ppu_we   (ppu_we),
        .nt_sel   (nt_sel),
        .chr_addr (chr_addr),
        .chr_we   (chr_we)
    );
endmodule

// File: rtl/mcm_mapper_chk.sv
module mcm_mapper_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        cpu_we,
    input logic [13:0] ppu_addr,
    input logic        ppu_we,
    input logic [20:0] rom_addr,
    input logic        nt_sel,
    input logic        chr_we
);
    logic even_wr, odd_wr;
    assign even_wr = cpu_we && cpu_addr[15] && !cpu_addr[0];
    assign odd_wr  = cpu_we && cpu_addr[15] &&  cpu_addr[0];

    p_odd_page_bit_r2: assert property (@(posedge clk) disable iff (rst)
        odd_wr |=> rom_addr[20] == $past(cpu_wdata[0]));

    p_even_page_bits_r2: assert property (@(posedge clk) disable iff (rst)
        even_wr |=> rom_addr[19:15] == {$past(cpu_wdata[7]), $past(cpu_wdata[4:1])});

    p_low_write_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (cpu_we && !cpu_addr[15]) |=> $stable(rom_addr[20:15]));

    p_half_select_r6: assert property (@(posedge clk) disable iff (rst)
        (even_wr && cpu_wdata[5]) |=> rom_addr[14] == $past(cpu_wdata[0]));

    p_mirror_r7: assert property (@(posedge clk) disable iff (rst)
        (even_wr && $stable(ppu_addr)) |=>
            nt_sel == ($past(cpu_wdata[6]) ? ppu_addr[10] : ppu_addr[11]));

    p_chr_gate_r8: assert property (@(posedge clk) disable iff (rst)
        chr_we |-> (ppu_we && !ppu_addr[13]));

    p_protect_r8: assert property (@(posedge clk) disable iff (rst)
        (odd_wr && cpu_wdata[1]) |=> !chr_we);
endmodule

bind mcm_mapper mcm_mapper_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .ppu_addr  (ppu_addr),
    .ppu_we    (ppu_we),
    .rom_addr  (rom_addr),
    .nt_sel    (nt_sel),
    .chr_we    (chr_we)
);

// File: tb/mcm_mapper_tb.sv
module mcm_mapper_tb_top;
    localparam time CLK_P = 8ns;

    typedef struct {
        string       tag;
        logic [20:0] rom;
        logic        nt;
        logic [12:0] caddr;
        logic        cwe;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic        ppu_we = 1'b0;
    logic [20:0] rom_addr;
    logic        nt_sel;
    logic [12:0] chr_addr;
    logic        chr_we;

    int n_run = 0;
    int n_fail = 0;

    logic [5:0] m_page = '0;
    logic m_mir = 0, m_z = 0, m_q = 0, m_w = 0;

    exp_t sb_q[$];
    event chk_ev;

    always #(CLK_P/2) clk = ~clk;

    mcm_mapper dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .ppu_addr(ppu_addr), .ppu_we(ppu_we),
        .rom_addr(rom_addr), .nt_sel(nt_sel), .chr_addr(chr_addr), .chr_we(chr_we)
    );

    // monitor: pops expected items and compares with outputs
    initial forever begin
        @(chk_ev);
        if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (rom_addr !== e.rom || nt_sel !== e.nt || chr_addr !== e.caddr || chr_we !== e.cwe) begin
                n_fail++;
                $display("FAIL %s: rom=%h nt=%b caddr=%h cwe=%b expected rom=%h nt=%b caddr=%h cwe=%b",
                         e.tag, rom_addr, nt_sel, chr_addr, chr_we, e.rom, e.nt, e.caddr, e.cwe);
            end
        end
    end

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        m_page = '0; m_mir = 0; m_z = 0; m_q = 0; m_w = 0;
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
        if (a[15]) begin
            if (a[0]) begin m_page[5] = d[0]; m_w = d[1]; end
            else begin
                m_page[4] = d[7]; m_mir = d[6]; m_z = d[5];
                m_page[3:0] = d[4:1]; m_q = d[0];
            end
        end
    endtask

    // driver: applies a probe and pushes the expected item
    task automatic probe(input string tag, input logic [15:0] ca,
                         input logic [13:0] pa, input logic pw);
        exp_t e;
        @(negedge clk);
        cpu_addr = ca; ppu_addr = pa; ppu_we = pw;
        #1;
        e.tag   = tag;
        e.rom   = {m_page, (m_z ? m_q : ca[14]), ca[13:0]};
        e.nt    = m_mir ? pa[10] : pa[11];
        e.caddr = pa[12:0];
        e.cwe   = pw & ~pa[13] & ~m_w;
        sb_q.push_back(e);
        ->chk_ev;
        #1;
    endtask

    initial begin : watchdog
        #(CLK_P * 20000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        probe("R1 reset rom", 16'hC123, 14'h0800, 1'b1);
        probe("R1 reset nt",  16'h8000, 14'h0C00, 1'b0);

        // R2 even/odd decode, R5 32K mode
        cpu_write(16'h8000, 8'b1_0_0_0101_0);   // p4=1 page[3:0]=5, 32K
        probe("R2 R5 even load lower window", 16'h8ABC, 14'h0400, 1'b0);
        probe("R5 upper window", 16'hF00F, 14'h0400, 1'b0);
        cpu_write(16'hBFFF, 8'h01);             // odd: p5=1
        probe("R2 odd load page5", 16'hC000, 14'h0000, 1'b1);

        // R3 low writes ignored
        cpu_write(16'h7FFE, 8'hFF);
        cpu_write(16'h4001, 8'hFF);
        probe("R3 low write ignored", 16'hC555, 14'h0C00, 1'b1);

        // R4 odd high bits ignored
        cpu_write(16'h8001, 8'hFC);
        probe("R4 odd high bits ignored", 16'hE001, 14'h1FFF, 1'b1);

        // R6 16K modes, R7 mirroring
        cpu_write(16'h9002, 8'b0_1_1_0011_1);   // vmirror, 16K, upper
        probe("R6 upper half at 8000", 16'h8123, 14'h0400, 1'b0);
        probe("R6 upper half at C000", 16'hC123, 14'h0800, 1'b0);
        probe("R7 vertical mirroring", 16'h8000, 14'h0C00, 1'b0);
        cpu_write(16'hFFFE, 8'b0_0_1_0011_0);   // hmirror, 16K, lower
        probe("R6 lower half at C000", 16'hFFFF, 14'h0400, 1'b0);
        probe("R7 horizontal mirroring", 16'hFFFF, 14'h0800, 1'b0);

        // R8 pattern write gating
        probe("R8 nametable write no chr_we", 16'h8000, 14'h2400, 1'b1);
        cpu_write(16'h8003, 8'h02);
        probe("R8 protect blocks chr_we", 16'h8000, 14'h1234, 1'b1);
        cpu_write(16'h8003, 8'h00);
        probe("R8 unprotect passes chr_we", 16'h8000, 14'h1234, 1'b1);

        // R9 worked example
        cpu_write(16'hEDCC, 8'h76);
        cpu_write(16'hA899, 8'h03);
        probe("R9 example lower at 8000", 16'h8010, 14'h0400, 1'b1);
        probe("R9 example lower at C000", 16'hFFFF, 14'h0800, 1'b1);
        if (m_page != 6'd43) begin
            n_fail++;
            $display("FAIL R9 model page: actual=%0d expected=43", m_page);
        end

        // R10 hold
        repeat (50) @(negedge clk);
        probe("R10 state held", 16'hC777, 14'h0C00, 1'b1);

        // R1 reset mid-run
        do_reset();
        probe("R1 reset clears after use", 16'hF234, 14'h0C00, 1'b1);

        @(negedge clk);
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule